// File: doc/BRIEF.md
# Indexed Clock Register File with Interrupt Flags

This block is the host-facing register front end of a real-time clock. It has a byte-wide bus with a single address bit. An access with the address bit low loads a register index. An access with the address bit high reads or writes the register that index selects, in a 128-entry byte space. Most entries are plain storage. Four fixed entries have their own behaviour:

- a rate/divider control register that carries a read-only busy flag;
- an enable/mode register;
- an event flag register that clears when it is read;
- a read-only validity register.

The time-keeping logic sits next to this block and reports through single-cycle pulses: a periodic tick, an alarm match, an update-ended event and an update-start (busy) strobe. The block latches each pulse as a flag. It then gates the flags with the enables to drive one level interrupt line. Software takes an interrupt by reading the flag register, and that read drops the line.

Read data is combinational from the current state. Side effects of an access (index load, register writes, the clear on a flag read) take effect at the next rising clock edge.

Top module: `rtcreg_top`

## Requirements
- R1: A write with `busSel`=0 loads `wrData[6:0]` as the register index. A read with `busSel`=0 returns 0xFF.
- R2: Every index other than 0x0A, 0x0B, 0x0C and 0x0D is plain storage. A data access (`busSel`=1) reads back the last byte written at that index.
- R3: Index 0x0A is the rate/divider control register.
  - Bits 6:0 are writable.
  - Bit 7 is a read-only busy flag. A `busySet` pulse sets it. An `updateEvt` pulse, or a write to 0x0B with bit 7 high, clears it.
  - A write to 0x0A never changes bit 7.
- R4: Index 0x0C is the flag register.
  - Bit layout: bit 7 is the summary flag, bit 6 periodic, bit 5 alarm, bit 4 update-ended, and bits 3:0 always read 0.
  - A data read returns the current flags and then clears all of them, so `irqOut` is low after that edge unless an event arrives in the same cycle. Such an event is kept.
  - Writes to 0x0C are ignored.
- R5: Index 0x0D always reads 0x80, and writes to it are ignored.
- R6: A write to 0x0B (enable register) sets the summary flag and `irqOut` after that edge if any of written bits 6:4 matches a flag bit 6:4 already set. Otherwise it clears the summary flag and `irqOut`.
  - The enable bits are: bit 6 periodic, bit 5 alarm, bit 4 update-ended.
- R7: A write to 0x0B with bit 7 (SET) high stores bit 4 as 0, whatever was written there.
- R8: An event pulse sets its flag bit.
  - A periodic pulse raises the summary flag whenever the periodic enable (bit 6) is set.
  - An alarm or update-ended pulse raises it only if that flag was not already set and its enable is set.
  - `irqOut` always equals the summary flag.
- R9: After `rstN` is released: 0x0A reads 0x26, 0x0B reads 0x02, 0x0C reads 0x00, 0x0D reads 0x80, the index is 0, and `irqOut` is low.
- R10: A `softRst` cycle does three things:
  - It clears bits 6, 5 and 3 of 0x0B, applied after any write in the same cycle.
  - It clears all flags and drops `irqOut`.
  - It leaves the other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| softRst | input | 1 | Synchronous device reset pulse |
| busSel | input | 1 | Address bit: 0 selects the index, 1 selects the data |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe (triggers read side effects) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the current address and index |
| periodicEvt | input | 1 | Periodic tick pulse |
| alarmEvt | input | 1 | Alarm match pulse |
| updateEvt | input | 1 | Update-ended pulse |
| busySet | input | 1 | Update-start pulse that sets the busy flag |
| irqOut | output | 1 | Interrupt request, level |

## Verification
The bench drives a seeded random mix of index loads, data reads and writes over the special indices and random plain ones. Event pulses, busy pulses and rare soft resets are overlaid on that traffic. This exercises the flag logic with pulses that arrive while a flag is already pending, in the same cycle as a flag read, and alongside enable writes. It therefore separates "newly set" gating from plain level gating, and clear-then-set ordering from set-then-clear.

Directed cases cover three further situations. The first is an interrupt that is enabled while its flag is pending. The second is a SET write that carries the update-ended enable. The third is writes to the read-only registers and to bit 7 of 0x0A, where the bench reads back the register each write could have touched.

// File: rtl/rtcreg_pkg.sv
package rtcreg_pkg;
  localparam int DATA_W = 8;

  // fixed special register indices (software decodes these)
  localparam int IDX_CTRL_A = 10;
  localparam int IDX_CTRL_B = 11;
  localparam int IDX_FLAGS  = 12;
  localparam int IDX_VALID  = 13;

  // bit positions shared by flag and enable registers
  localparam int BIT_SUM  = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_ALM  = 5;
  localparam int BIT_UPD  = 4;
  localparam int BIT_SET  = 7;
  localparam int BIT_SQW  = 3;

  localparam logic [DATA_W-1:0] RST_CTRL_A = 8'h26;
  localparam logic [DATA_W-1:0] RST_CTRL_B = 8'h02;
  localparam logic [DATA_W-1:0] VALID_VAL  = 8'h80;
  localparam logic [DATA_W-1:0] SOFT_CLR_B =
    (8'h1 << BIT_PER) | (8'h1 << BIT_ALM) | (8'h1 << BIT_SQW);

  typedef struct packed {
    logic wrA;
    logic wrB;
    logic wrPlain;
    logic rdFlags;
  } strobe_t;
endpackage

// File: rtl/rtcreg_ctrl.sv
module rtcreg_ctrl
  import rtcreg_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strobe,
  output logic [IDX_W-1:0]  curIdx
);
  localparam logic [IDX_W-1:0] IA = IDX_W'(IDX_CTRL_A);
  localparam logic [IDX_W-1:0] IB = IDX_W'(IDX_CTRL_B);
  localparam logic [IDX_W-1:0] IC = IDX_W'(IDX_FLAGS);
  localparam logic [IDX_W-1:0] ID = IDX_W'(IDX_VALID);

  logic dataWr;
  logic isSpecial;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      curIdx <= '0;
    else if (wrEn && !busSel)
      curIdx <= wrData[IDX_W-1:0];
  end

  always_comb begin
    dataWr         = wrEn && busSel;
    isSpecial      = (curIdx == IA) || (curIdx == IB) ||
                     (curIdx == IC) || (curIdx == ID);
    strobe.wrA     = dataWr && (curIdx == IA);
    strobe.wrB     = dataWr && (curIdx == IB);
    strobe.wrPlain = dataWr && !isSpecial;
    strobe.rdFlags = rdEn && busSel && (curIdx == IC);
  end
endmodule

// File: rtl/rtcreg_datapath.sv
module rtcreg_datapath
  import rtcreg_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  strobe_t           strobe,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic              busSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              periodicEvt,
  input  logic              alarmEvt,
  input  logic              updateEvt,
  input  logic              busySet,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [6:0]        ctrlA;
  logic              uip;
  logic [DATA_W-1:0] ctrlB;
  logic [3:0]        flags;     // {sum, per, alm, upd}

  logic [DATA_W-1:0] bNext;
  logic [3:0]        flagNext;
  logic              raise;
  logic              newAlm;
  logic              newUpd;
  logic              setWrite;

  // plain storage
  always_ff @(posedge clk) begin
    if (strobe.wrPlain)
      store[curIdx] <= wrData;
  end

  always_comb begin
    setWrite = strobe.wrB && wrData[BIT_SET];
    bNext    = ctrlB;
    if (strobe.wrB) begin
      bNext = wrData;
      if (wrData[BIT_SET])
        bNext[BIT_UPD] = 1'b0;
    end

    flagNext = flags;
    if (strobe.rdFlags)
      flagNext = '0;
    if (strobe.wrB)
      flagNext[3] = |(bNext[BIT_PER:BIT_UPD] & flags[2:0]);

    newAlm = alarmEvt  && !flagNext[1];
    newUpd = updateEvt && !flagNext[0];
    if (periodicEvt) flagNext[2] = 1'b1;
    if (alarmEvt)    flagNext[1] = 1'b1;
    if (updateEvt)   flagNext[0] = 1'b1;
    raise = (periodicEvt && bNext[BIT_PER]) ||
            (newAlm && bNext[BIT_ALM]) ||
            (newUpd && bNext[BIT_UPD]);
    if (raise)
      flagNext[3] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlA <= RST_CTRL_A[6:0];
      uip   <= RST_CTRL_A[7];
      ctrlB <= RST_CTRL_B;
      flags <= '0;
    end else begin
      if (strobe.wrA)
        ctrlA <= wrData[6:0];
      if (setWrite || updateEvt)
        uip <= 1'b0;
      else if (busySet)
        uip <= 1'b1;
      ctrlB <= softRst ? (bNext & ~SOFT_CLR_B) : bNext;
      flags <= softRst ? 4'b0 : flagNext;
    end
  end

  always_comb begin
    if (!busSel)
      rdData = 8'hFF;
    else begin
      unique case (int'(curIdx))
        IDX_CTRL_A: rdData = {uip, ctrlA};
        IDX_CTRL_B: rdData = ctrlB;
        IDX_FLAGS:  rdData = {flags, 4'b0};
        IDX_VALID:  rdData = VALID_VAL;
        default:    rdData = store[curIdx];
      endcase
    end
  end

  assign irqOut = flags[3];
endmodule

// File: rtl/rtcreg_top.sv
module rtcreg_top
  import rtcreg_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       busSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       periodicEvt,
  input  logic       alarmEvt,
  input  logic       updateEvt,
  input  logic       busySet,
  output logic       irqOut
);
  strobe_t          strobe;
  logic [IDX_W-1:0] curIdx;

  rtcreg_ctrl #(.IDX_W(IDX_W)) ctrlI (
    .clk(clk), .rstN(rstN), .busSel(busSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .strobe(strobe), .curIdx(curIdx)
  );

  rtcreg_datapath #(.IDX_W(IDX_W)) dpI (
    .clk(clk), .rstN(rstN), .softRst(softRst), .strobe(strobe),
    .curIdx(curIdx), .busSel(busSel), .wrData(wrData),
    .periodicEvt(periodicEvt), .alarmEvt(alarmEvt), .updateEvt(updateEvt),
    .busySet(busySet), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/rtcreg_chk.sv
module rtcreg_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             softRst,
  input logic             busSel,
  input logic             wrEn,
  input logic             rdEn,
  input logic [7:0]       wrData,
  input logic [7:0]       rdData,
  input logic             periodicEvt,
  input logic             alarmEvt,
  input logic             updateEvt,
  input logic             busySet,
  input logic             irqOut,
  input logic [IDX_W-1:0] curIdx,
  input logic [7:0]       ctrlB,
  input logic             uipBit
);
  logic anyEvt;
  assign anyEvt = periodicEvt || alarmEvt || updateEvt;

  // R1: index-side read always returns all ones
  a_r1_index_read_ff: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> rdData == 8'hFF);

  // R4: flag read with no concurrent event leaves the interrupt low
  a_r4_read_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busSel && curIdx == IDX_W'(12) && !anyEvt) |=> !irqOut);

  // R7: SET write never leaves the update-ended enable high
  a_r7_set_masks_uie: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busSel && curIdx == IDX_W'(11) && wrData[7]) |=> !ctrlB[4]);

  // R3: writing control A leaves the busy bit alone
  a_r3_busy_readonly: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busSel && curIdx == IDX_W'(10) && !updateEvt && !busySet)
      |=> uipBit == $past(uipBit));

  // R10: device reset drops the interrupt and the masked enables
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!irqOut && !ctrlB[6] && !ctrlB[5] && !ctrlB[3]));
endmodule

bind rtcreg_top rtcreg_chk #(.IDX_W(IDX_W)) chkI (
  .clk(clk), .rstN(rstN), .softRst(softRst), .busSel(busSel),
  .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData),
  .periodicEvt(periodicEvt), .alarmEvt(alarmEvt), .updateEvt(updateEvt),
  .busySet(busySet), .irqOut(irqOut), .curIdx(curIdx),
  .ctrlB(dpI.ctrlB), .uipBit(dpI.uip)
);

// File: tb/rtcreg_top_tb_top.sv
module rtcreg_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softRst = 1'b0;
  logic       busSel = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h0;
  logic [7:0] rdData;
  logic       periodicEvt = 1'b0;
  logic       alarmEvt = 1'b0;
  logic       updateEvt = 1'b0;
  logic       busySet = 1'b0;
  logic       irqOut;

  int testCnt = 0;
  int failCnt = 0;

  // bench model of the register space
  logic [7:0] mMem [128];
  logic [6:0] mIdx;
  logic [6:0] mA;
  logic       mUip;
  logic [7:0] mB;
  logic [7:0] mFl;

  always #4 clk = ~clk;

  rtcreg_top dut_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .busSel(busSel),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData),
    .periodicEvt(periodicEvt), .alarmEvt(alarmEvt), .updateEvt(updateEvt),
    .busySet(busySet), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic s);
    if (!s) return 8'hFF;
    case (mIdx)
      7'd10:   return {mUip, mA};
      7'd11:   return mB;
      7'd12:   return mFl;
      7'd13:   return 8'h80;
      default: return mMem[mIdx];
    endcase
  endfunction

  function automatic string readTag(input logic s);
    if (!s) return "R1 index read";
    case (mIdx)
      7'd10:   return "R3 control A read";
      7'd11:   return "R7 enable reg read";
      7'd12:   return "R4 flag read";
      7'd13:   return "R5 validity read";
      default: return "R2 plain read";
    endcase
  endfunction

  // one bus cycle, starting and ending at a falling edge
  task automatic cyc(input logic s, input logic w, input logic r,
                     input logic [7:0] d, input logic pe, input logic ae,
                     input logic ue, input logic bs, input logic sr);
    logic [7:0] fl;
    logic [7:0] bN;
    logic newA;
    logic newU;
    busSel = s; wrEn = w; rdEn = r; wrData = d;
    periodicEvt = pe; alarmEvt = ae; updateEvt = ue; busySet = bs;
    softRst = sr;
    #1;
    if (r) check(rdData === expRead(s), readTag(s), rdData, expRead(s));
    @(posedge clk);
    fl = mFl;
    bN = mB;
    if (r && s && mIdx == 7'd12) fl = 8'h00;
    if (w && s && mIdx == 7'd11) begin
      bN = d;
      if (d[7]) bN[4] = 1'b0;
      fl[7] = |(bN[6:4] & mFl[6:4]);
    end
    newA = ae && !fl[5];
    newU = ue && !fl[4];
    if (pe) fl[6] = 1'b1;
    if (ae) fl[5] = 1'b1;
    if (ue) fl[4] = 1'b1;
    if ((pe && bN[6]) || (newA && bN[5]) || (newU && bN[4])) fl[7] = 1'b1;
    if ((w && s && mIdx == 7'd11 && d[7]) || ue) mUip = 1'b0;
    else if (bs) mUip = 1'b1;
    if (w && s && mIdx == 7'd10) mA = d[6:0];
    if (w && s && !(mIdx inside {7'd10, 7'd11, 7'd12, 7'd13})) mMem[mIdx] = d;
    if (sr) begin
      bN = bN & ~8'h68;
      fl = 8'h00;
    end
    mB = bN;
    mFl = fl;
    if (w && !s) mIdx = d[6:0];
    @(negedge clk);
    busSel = 1'b0; wrEn = 1'b0; rdEn = 1'b0; wrData = 8'h0;
    periodicEvt = 1'b0; alarmEvt = 1'b0; updateEvt = 1'b0; busySet = 1'b0;
    softRst = 1'b0;
    check(irqOut === mFl[7], "R8 irq level", {7'b0, irqOut}, {7'b0, mFl[7]});
  endtask

  task automatic setIdx(input logic [6:0] i);
    cyc(1'b0, 1'b1, 1'b0, {1'b0, i}, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic wrReg(input logic [6:0] i, input logic [7:0] d);
    setIdx(i);
    cyc(1'b1, 1'b1, 1'b0, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic rdReg(input logic [6:0] i);
    setIdx(i);
    cyc(1'b1, 1'b0, 1'b1, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic evt(input logic pe, input logic ae, input logic ue);
    cyc(1'b0, 1'b0, 1'b0, 8'h0, pe, ae, ue, 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    mIdx = '0; mA = 7'h26; mUip = 1'b0; mB = 8'h02; mFl = 8'h00;
    for (int i = 0; i < 128; i++) mMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: power-up values
    rdReg(7'd10); rdReg(7'd11); rdReg(7'd12); rdReg(7'd13);
    check(irqOut === 1'b0, "R9 irq low after reset", {7'b0, irqOut}, 8'h00);

    // R1: index-side read
    cyc(1'b0, 1'b0, 1'b1, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R2: plain storage in every non-special index used
    for (int i = 0; i < 128; i += 9) wrReg(7'(i), 8'(i * 3 + 1));
    wrReg(7'd14, 8'hA5); wrReg(7'd127, 8'h5A);
    for (int i = 0; i < 128; i += 9) rdReg(7'(i));
    rdReg(7'd14); rdReg(7'd127);

    // R5 / R4: read-only registers ignore writes
    wrReg(7'd13, 8'h00); rdReg(7'd13);
    wrReg(7'd12, 8'hF0); rdReg(7'd12);

    // R3: busy bit set by pulse, kept across control A write
    cyc(1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    wrReg(7'd10, 8'h00); rdReg(7'd10);
    wrReg(7'd10, 8'hFF); rdReg(7'd10);

    // R6: pending flag then enable raises the interrupt
    wrReg(7'd11, 8'h02);
    evt(1'b0, 1'b0, 1'b1);
    check(irqOut === 1'b0, "R8 disabled event no irq", {7'b0, irqOut}, 8'h00);
    wrReg(7'd11, 8'h12);
    check(irqOut === 1'b1, "R6 enable pending raises irq", {7'b0, irqOut}, 8'h01);
    rdReg(7'd12);
    check(irqOut === 1'b0, "R4 read clears irq", {7'b0, irqOut}, 8'h00);

    // R8: repeated update event while flag set does not re-raise
    evt(1'b0, 1'b0, 1'b1);
    wrReg(7'd11, 8'h12);
    setIdx(7'd12);
    cyc(1'b1, 1'b0, 1'b1, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    wrReg(7'd11, 8'h02);
    evt(1'b0, 1'b0, 1'b1);
    wrReg(7'd11, 8'h02);
    evt(1'b0, 1'b0, 1'b1);
    check(irqOut === 1'b0, "R8 stale flag no raise", {7'b0, irqOut}, 8'h00);

    // R7: SET write masks update enable and clears busy
    cyc(1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    wrReg(7'd11, 8'hF6); rdReg(7'd11); rdReg(7'd10);

    // R10: soft reset
    wrReg(7'd11, 8'h6A);
    evt(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check(irqOut === 1'b0, "R10 soft reset drops irq", {7'b0, irqOut}, 8'h00);
    rdReg(7'd11); rdReg(7'd12); rdReg(7'd14);

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      int op;
      logic [6:0] ri;
      logic [7:0] rd;
      op = int'($urandom % 4);
      case ($urandom % 6)
        0: ri = 7'd10; 1: ri = 7'd11; 2, 3: ri = 7'd12; 4: ri = 7'd13;
        default: ri = 7'($urandom % 128);
      endcase
      rd = 8'($urandom);
      cyc(op != 0, (op == 0) || (op == 1), op >= 2, (op == 0) ? {1'b0, ri} : rd,
          ($urandom % 6) == 0, ($urandom % 8) == 0, ($urandom % 6) == 0,
          ($urandom % 8) == 0, ($urandom % 60) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule